// File: doc/BRIEF.md
# Strobed Output Handshake Channel

This block is the output half of one strobed parallel-port group. The CPU side writes a byte with an active-low write strobe. On the rising edge of that strobe the byte is captured into an output latch, and an active-low buffer-full flag goes low to tell the peripheral that data is waiting. The peripheral takes the byte and pulls its active-low acknowledge input low. That clears the buffer-full condition. Once acknowledge has returned high, and if the interrupt enable is set, an interrupt request is raised to the CPU. The next falling edge of the CPU write strobe clears that request.

The interrupt enable is a single flag. It is changed by a bit set/reset command aimed at the handshake nibble of the control port. Group A uses bit 6 and group B uses bit 2, selected by a parameter. The write strobe and the acknowledge are asynchronous. Each passes through its own synchroniser, and edges are found on the synchronised copies. A status word carries the buffer-full, enable and request bits at the positions the handshake nibble gives them, so the CPU can poll instead of taking the interrupt.

The data path is a strobe handshake, not a valid/ready stream, so there is no back-pressure at the edge. The peripheral paces the transfer only through the acknowledge, and the CPU is expected to watch the buffer-full flag or the interrupt before it writes again. A write that arrives while the buffer is still full overwrites the latch.

Top module: `strobed_out_chan`

## Requirements
- R1: While reset is asserted and just after it is released, obf_n_o is 1, intr_o is 0, the enable is 0 and port_o is 0. For group A this makes status_o equal 8'h80.
- R2: A rising edge on wr_n_i loads wr_data_i into port_o and drives obf_n_o low. Both changes take effect on the third rising clock edge after wr_n_i goes high, and not earlier. wr_data_i must be held from the fall of wr_n_i until four clocks after its rise.
- R3: A low level on ack_n_i drives obf_n_o high on the third clock edge after ack_n_i falls. Acknowledge never changes port_o.
- R4: intr_o is 1 only when, in the previous cycle, the synchronised acknowledge was high, obf_n_o was high, the enable was 1 and the synchronised write strobe was high without a rising edge. In steady state with both strobes high, intr_o equals the enable AND obf_n_o.
- R5: A falling edge on wr_n_i forces intr_o to 0 by the third clock edge, and intr_o stays 0 while wr_n_i is held low.
- R6: When bsr_valid_i is high and bsr_bit_i equals the enable bit (6 for group A, 2 for group B), the enable takes the value of bsr_set_i on the next clock edge. A command with any other bit index leaves the enable unchanged.
- R7: status_o for group A holds obf_n in bit 7, the enable in bit 6 and intr in bit 3, with all other bits 0. For group B it holds the enable in bit 2, obf_n in bit 1 and intr in bit 0, with all other bits 0.
- R8: If a synchronised write rising edge and a synchronised low acknowledge fall in the same cycle, the write wins and obf_n_o goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_n_i | input | 1 | Asynchronous CPU write strobe, active low |
| wr_data_i | input | DATA_W | Byte to be latched on the write rising edge |
| ack_n_i | input | 1 | Asynchronous peripheral acknowledge, active low |
| bsr_valid_i | input | 1 | Bit set/reset command strobe, one clock |
| bsr_bit_i | input | 3 | Bit index of the set/reset command |
| bsr_set_i | input | 1 | Value written by the set/reset command |
| port_o | output | DATA_W | Output latch driven to the peripheral |
| obf_n_o | output | 1 | Buffer-full flag to the peripheral, active low |
| intr_o | output | 1 | Interrupt request to the CPU |
| status_o | output | 8 | Polled status in handshake-nibble layout |

## Verification
The assertions assume that each strobe stays at a level for at least one clock, so the synchronisers never drop a pulse. They also assume that set/reset commands come as single-cycle bsr_valid_i pulses in step with clk. The stimulus drives every input on the falling clock edge. It holds wr_n_i low for one to five cycles and ack_n_i low for one to four cycles. It keeps wr_data_i constant through each write and for six cycles after it, so the sampled byte is always the one the bench expects. Random operations are spaced far enough apart that each reaches steady state before the next begins, except in the directed case that makes write and acknowledge coincide.

// File: rtl/sochan_pkg.sv
package sochan_pkg;

  typedef enum logic {
    GRP_A = 1'b0,
    GRP_B = 1'b1
  } grp_e;

  // Handshake nibble positions; the enable index is the one the
  // set/reset command must name.
  function automatic int inte_pos(grp_e g);
    return (g == GRP_A) ? 6 : 2;
  endfunction

  function automatic int obf_pos(grp_e g);
    return (g == GRP_A) ? 7 : 1;
  endfunction

  function automatic int intr_pos(grp_e g);
    return (g == GRP_A) ? 3 : 0;
  endfunction

endpackage

// File: rtl/sochan_sync.sv
module sochan_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
  assign rise_o = sync_o & ~prev_q;
  assign fall_o = ~sync_o & prev_q;

endmodule

// File: rtl/sochan_inte.sv
module sochan_inte #(
  parameter int NIB_W  = 8,
  parameter int EN_BIT = 6,
  localparam int SEL_W = $clog2(NIB_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  input  logic [SEL_W-1:0] cmd_bit_i,
  input  logic             cmd_set_i,
  output logic             inte_o
);

  logic hit;

  assign hit = cmd_valid_i && (cmd_bit_i == SEL_W'(EN_BIT));

  always_ff @(posedge clk) begin
    if (!rst_n)   inte_o <= 1'b0;
    else if (hit) inte_o <= cmd_set_i;
  end

endmodule

// File: rtl/sochan_flags.sv
module sochan_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sync_i,
  input  logic              wr_rise_i,
  input  logic              ack_sync_i,
  input  logic              inte_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] port_o,
  output logic              obf_n_o,
  output logic              intr_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_o  <= '0;
      obf_n_o <= 1'b1;
    end else if (wr_rise_i) begin
      port_o  <= data_i;
      obf_n_o <= 1'b0;
    end else if (!ack_sync_i) begin
      obf_n_o <= 1'b1;
    end
  end

  // Request is a registered level; a write in progress keeps it low.
  always_ff @(posedge clk) begin
    if (!rst_n) intr_o <= 1'b0;
    else        intr_o <= ack_sync_i & obf_n_o & inte_i & wr_sync_i & ~wr_rise_i;
  end

endmodule

// File: rtl/strobed_out_chan.sv
module strobed_out_chan
  import sochan_pkg::*;
#(
  parameter int   DATA_W      = 8,
  parameter int   SYNC_STAGES = 2,
  parameter grp_e GROUP       = GRP_A,
  localparam int  NIB_W       = 8,
  localparam int  SEL_W       = $clog2(NIB_W),
  localparam int  EN_BIT      = inte_pos(GROUP),
  localparam int  OBF_BIT     = obf_pos(GROUP),
  localparam int  INTR_BIT    = intr_pos(GROUP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ack_n_i,
  input  logic              bsr_valid_i,
  input  logic [SEL_W-1:0]  bsr_bit_i,
  input  logic              bsr_set_i,
  output logic [DATA_W-1:0] port_o,
  output logic              obf_n_o,
  output logic              intr_o,
  output logic [NIB_W-1:0]  status_o
);

  logic wr_sync, wr_rise, wr_fall;
  logic ack_sync, ack_rise, ack_fall;
  logic inte;

  sochan_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) wr_sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(wr_n_i),
    .sync_o(wr_sync), .rise_o(wr_rise), .fall_o(wr_fall)
  );

  sochan_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) ack_sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(ack_n_i),
    .sync_o(ack_sync), .rise_o(ack_rise), .fall_o(ack_fall)
  );

  sochan_inte #(.NIB_W(NIB_W), .EN_BIT(EN_BIT)) inte_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(bsr_valid_i),
    .cmd_bit_i(bsr_bit_i), .cmd_set_i(bsr_set_i), .inte_o(inte)
  );

  sochan_flags #(.DATA_W(DATA_W)) flags_i (
    .clk(clk), .rst_n(rst_n), .wr_sync_i(wr_sync), .wr_rise_i(wr_rise),
    .ack_sync_i(ack_sync), .inte_i(inte), .data_i(wr_data_i),
    .port_o(port_o), .obf_n_o(obf_n_o), .intr_o(intr_o)
  );

  // Acknowledge edges are not used by the flag logic (level-driven).
  logic ack_edge_unused;
  assign ack_edge_unused = ack_rise ^ ack_fall;

  genvar b;
  generate
    for (b = 0; b < NIB_W; b++) begin : g_stat
      if (b == OBF_BIT) begin : g_obf
        assign status_o[b] = obf_n_o;
      end else if (b == EN_BIT) begin : g_en
        assign status_o[b] = inte;
      end else if (b == INTR_BIT) begin : g_irq
        assign status_o[b] = intr_o;
      end else begin : g_zero
        assign status_o[b] = 1'b0 & ack_edge_unused;
      end
    end
  endgenerate

endmodule

// File: rtl/strobed_out_chan_chk.sv
module strobed_out_chan_chk #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int EN_BIT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_rise,
  input logic              wr_fall,
  input logic              ack_sync,
  input logic              inte,
  input logic              bsr_valid_i,
  input logic [SEL_W-1:0]  bsr_bit_i,
  input logic [DATA_W-1:0] port_o,
  input logic              obf_n_o,
  input logic              intr_o
);

  assert_fill_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(obf_n_o) |-> $past(wr_rise));

  assert_latch_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_o) |-> $past(wr_rise));

  assert_empty_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf_n_o) |-> $past(!ack_sync));

  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    intr_o |-> (obf_n_o && $past(inte) && $past(ack_sync)));

  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall |=> !intr_o);

  assert_enable_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(inte) |-> $past(bsr_valid_i && (bsr_bit_i == SEL_W'(EN_BIT))));

endmodule

bind strobed_out_chan strobed_out_chan_chk #(
  .DATA_W(DATA_W), .SEL_W(SEL_W), .EN_BIT(EN_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_rise(wr_rise), .wr_fall(wr_fall),
  .ack_sync(ack_sync), .inte(inte), .bsr_valid_i(bsr_valid_i),
  .bsr_bit_i(bsr_bit_i), .port_o(port_o), .obf_n_o(obf_n_o), .intr_o(intr_o)
);

// File: tb/strobed_out_chan_tb_top.sv
`timescale 1ns/1ps
module strobed_out_chan_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_n = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic       ack_n = 1'b1;
  logic       bsr_valid = 1'b0;
  logic [2:0] bsr_bit = 3'd0;
  logic       bsr_set = 1'b0;
  logic [7:0] port;
  logic       obf_n;
  logic       intr;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state, computed from the requirements.
  logic [7:0] m_port = 8'h00;
  logic       m_obf_n = 1'b1;
  logic       m_inte = 1'b0;

  always #2 clk = ~clk;

  strobed_out_chan dut_i (
    .clk(clk), .rst_n(rst_n), .wr_n_i(wr_n), .wr_data_i(wr_data),
    .ack_n_i(ack_n), .bsr_valid_i(bsr_valid), .bsr_bit_i(bsr_bit),
    .bsr_set_i(bsr_set), .port_o(port), .obf_n_o(obf_n), .intr_o(intr),
    .status_o(status)
  );

  // Group A status layout (R7): bit7 obf_n, bit6 enable, bit3 intr.
  function automatic logic [7:0] exp_status(logic o, logic e, logic i);
    return {o, e, 2'b00, i, 3'b000};
  endfunction

  function automatic logic exp_intr(logic o, logic e);
    return o & e;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_steady(input string req);
    check({req, " port"}, 32'(port), 32'(m_port));
    check({req, " obf_n"}, 32'(obf_n), 32'(m_obf_n));
    check({req, " intr"}, 32'(intr), 32'(exp_intr(m_obf_n, m_inte)));
    check({req, " status R7"}, 32'(status),
          32'(exp_status(m_obf_n, m_inte, exp_intr(m_obf_n, m_inte))));
  endtask

  task automatic do_write(input logic [7:0] d, input int low_cycles);
    @(negedge clk);
    wr_data = d;
    wr_n = 1'b0;
    repeat (low_cycles) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    m_port = d;
    m_obf_n = 1'b0;
  endtask

  task automatic do_ack(input int low_cycles);
    @(negedge clk);
    ack_n = 1'b0;
    repeat (low_cycles) @(negedge clk);
    ack_n = 1'b1;
    repeat (6) @(negedge clk);
    m_obf_n = 1'b1;
  endtask

  task automatic do_bsr(input logic [2:0] b, input logic v);
    @(negedge clk);
    bsr_valid = 1'b1;
    bsr_bit = b;
    bsr_set = v;
    @(negedge clk);
    bsr_valid = 1'b0;
    repeat (3) @(negedge clk);
    if (b == 3'd6) m_inte = v;
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (5) @(negedge clk);
    check("R1 obf_n in reset", 32'(obf_n), 32'h1);
    check("R1 intr in reset", 32'(intr), 32'h0);
    check("R1 port in reset", 32'(port), 32'h0);
    check("R1 status in reset", 32'(status), 32'h80);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_steady("R1 after release");

    // R6: a wrong bit index is ignored.
    do_bsr(3'd5, 1'b1);
    check_steady("R6 other index ignored");
    do_bsr(3'd2, 1'b1);
    check_steady("R6 group B index ignored");
    do_bsr(3'd6, 1'b1);
    check("R6 enable set", 32'(status[6]), 32'h1);
    check_steady("R4 idle with enable");

    // R5 / R2: write with latency checks.
    @(negedge clk);
    wr_data = 8'hA5;
    wr_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 intr low while write held", 32'(intr), 32'h0);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 obf_n not yet low", 32'(obf_n), 32'h1);
    check("R2 port not yet loaded", 32'(port), 32'h0);
    @(negedge clk);
    check("R2 obf_n low on third edge", 32'(obf_n), 32'h0);
    check("R2 port loaded", 32'(port), 32'hA5);
    repeat (4) @(negedge clk);
    m_port = 8'hA5;
    m_obf_n = 1'b0;
    check_steady("R4 no request while full");

    // R3: acknowledge latency.
    @(negedge clk);
    ack_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 obf_n not yet high", 32'(obf_n), 32'h0);
    @(negedge clk);
    check("R3 obf_n high on third edge", 32'(obf_n), 32'h1);
    check("R4 no request while ack low", 32'(intr), 32'h0);
    check("R3 port unchanged", 32'(port), 32'hA5);
    ack_n = 1'b1;
    repeat (5) @(negedge clk);
    m_obf_n = 1'b1;
    check_steady("R4 request after ack release");

    do_bsr(3'd6, 1'b0);
    check_steady("R6 enable cleared");
    do_bsr(3'd6, 1'b1);

    // R8: write rise and one-cycle ack coincide.
    @(negedge clk);
    wr_data = 8'h3C;
    wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    ack_n = 1'b0;
    @(negedge clk);
    ack_n = 1'b1;
    repeat (6) @(negedge clk);
    m_port = 8'h3C;
    m_obf_n = 1'b0;
    check_steady("R8 write wins over ack");
    do_ack(2);
    check_steady("R3 ack after R8");

    for (int n = 0; n < 300; n++) begin
      int op;
      op = int'($urandom_range(0, 3));
      case (op)
        0: do_write(8'($urandom), int'($urandom_range(1, 5)));
        1: do_ack(int'($urandom_range(1, 4)));
        2: do_bsr(3'($urandom), 1'($urandom));
        default: do_bsr(3'd6, 1'($urandom));
      endcase
      check_steady("R2 R3 R4 R6 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule